// File: doc/BRIEF.md
# Asynchronous Strobed Register-Bus Slave

This block lets a processor with an asynchronous, strobe-based bus read and write single bytes in a small on-chip register and buffer array. The processor first puts a 15-bit address on the bus and pulses the address strobe. The slave takes the address when that strobe returns high. The processor then picks the direction with the read/write line and pulls the data strobe low. The slave answers by pulling an active-low acknowledge line low. On a read, valid data is already on the bidirectional data bus when the acknowledge goes low.

Every bus input is asynchronous to the system clock. The strobes, chip select, the direction line and the data byte all pass through a two-flop synchroniser, and all edge detection uses the synchronised copies. The array is a single-port memory with `2**MEM_AW` byte locations and a registered read, so it can map onto block RAM. The low `MEM_AW` bits of the latched address select the location.

Top module: `mbus_slave`

## Requirements
- R1: After reset, `dtack_n` is high and the slave does not drive `bus_data`, so a value driven by the processor reads back unchanged.
- R2: The address is taken from `bus_addr` when the synchronised `as_n` rises while chip select is low. Later changes on `bus_addr` before the data strobe have no effect on which location is accessed.
- R3: A write cycle (`rw` = 0) writes the byte on `bus_data` exactly once per falling edge of `ds_n`. It uses location `addr mod 2**MEM_AW` of the latched address, so addresses that differ only above bit `MEM_AW-1` refer to the same location.
- R4: A read cycle (`rw` = 1) returns the byte most recently written to the selected location.
- R5: The slave drives `bus_data` only during a read in which the synchronised chip select and data strobe are both low.
- R6: On a read, the slave starts driving the data at least one clock before `dtack_n` falls.
- R7: Once the synchronised `ds_n` has been high for one clock, `dtack_n` is high. Measured at the pins, `dtack_n` returns high within four clocks after `ds_n` rises.
- R8: If `ds_n` falls while `cs_n` is high, nothing happens: the memory does not change and `dtack_n` stays high.
- R9: If no address has been latched since reset, a data-strobe cycle is ignored and gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 15 | Processor address bus |
| bus_data | inout | 8 | Bidirectional processor data bus |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low; the address is taken on its rising edge |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| ds_n | input | 1 | Data strobe, active low; its falling edge starts a transfer |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The in-RTL assertions check the following on every clock:
- the data bus is driven only while the synchronised chip select and data strobe are low;
- the acknowledge is never low while the strobe or chip select is inactive;
- a read's acknowledge always comes after the data drive began;
- a memory write strobe never lasts more than one clock;
- an address is always marked valid after a strobe rise.

Only the bench's scenarios can show the data path end to end. These scenarios cover:
- read-after-write values, including for aliased addresses;
- that a late change of address is ignored;
- that deselected or unaddressed cycles leave the memory untouched;
- the pin-level release time of the acknowledge.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Transfer sequencing state
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RLOAD  = 2'd1,
    ST_RDRIVE = 2'd2,
    ST_ACK    = 2'd3
  } mbus_state_e;

  // Positions of the bus controls inside the synchroniser bundle
  localparam int CTL_CS = 0;
  localparam int CTL_AS = 1;
  localparam int CTL_RW = 2;
  localparam int CTL_DS = 3;
  localparam int CTL_W  = 4;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mbus_alatch.sv
module mbus_alatch #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_s,     // synchronised address strobe, active low
  input  logic          cs_s,     // synchronised chip select, active low
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          addr_vld
);

  logic as_prev;
  logic as_rise;

  assign as_rise = !as_prev && as_s && !cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_prev  <= 1'b1;
      addr_q   <= '0;
      addr_vld <= 1'b0;
    end else begin
      as_prev <= as_s;
      if (as_rise) begin
        addr_q   <= addr_in;
        addr_vld <= 1'b1;
      end
    end
  end

  // R2: a qualifying strobe rise always leaves a valid address behind
  assert_addr_valid_R2: assert property (@(posedge clk) disable iff (rst)
    as_rise |=> addr_vld);

endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

  // R3: a write strobe is a single-clock pulse
  assert_single_write_R3: assert property (@(posedge clk)
    we |=> !we);

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MEM_AW    = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              rw,
  input  logic              ds_n,
  output logic              dtack_n
);

  import mbus_pkg::*;

  localparam logic [CTL_W-1:0] CTL_IDLE = '1;

  // Synchronised controls and data
  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [DATA_W-1:0] data_s;
  logic              cs_s, as_s, rw_s, ds_s;

  assign ctl_raw[CTL_CS] = cs_n;
  assign ctl_raw[CTL_AS] = as_n;
  assign ctl_raw[CTL_RW] = rw;
  assign ctl_raw[CTL_DS] = ds_n;

  mbus_sync #(.W(CTL_W), .STAGES(SYNC_DEPTH), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  mbus_sync #(.W(DATA_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst), .d(bus_data), .q(data_s)
  );

  assign cs_s = ctl_s[CTL_CS];
  assign as_s = ctl_s[CTL_AS];
  assign rw_s = ctl_s[CTL_RW];
  assign ds_s = ctl_s[CTL_DS];

  // Address latch
  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld;

  mbus_alatch #(.AW(ADDR_W)) u_alatch (
    .clk(clk), .rst(rst), .as_s(as_s), .cs_s(cs_s),
    .addr_in(bus_addr), .addr_q(addr_q), .addr_vld(addr_vld)
  );

  // Storage array
  logic              mem_we, mem_re;
  logic [DATA_W-1:0] mem_q;

  mbus_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .addr(addr_q[MEM_AW-1:0]), .we(mem_we), .wdata(data_s),
    .re(mem_re), .rdata(mem_q)
  );

  // Transfer control
  mbus_state_e       st, nxt;
  logic              ds_prev, ds_fall, abort;
  logic              cyc_rd, drive_en;
  logic [DATA_W-1:0] rd_data;

  assign ds_fall = ds_prev && !ds_s;
  assign abort   = ds_s || cs_s;

  always_comb begin
    nxt    = st;
    mem_we = 1'b0;
    mem_re = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ds_fall && !cs_s && addr_vld) begin
          if (rw_s) begin
            mem_re = 1'b1;
            nxt    = ST_RLOAD;
          end else begin
            mem_we = 1'b1;
            nxt    = ST_ACK;
          end
        end
      end
      ST_RLOAD:  nxt = abort ? ST_IDLE : ST_RDRIVE;
      ST_RDRIVE: nxt = abort ? ST_IDLE : ST_ACK;
      ST_ACK:    if (abort) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ds_prev  <= 1'b1;
      cyc_rd   <= 1'b0;
      dtack_n  <= 1'b1;
      drive_en <= 1'b0;
      rd_data  <= '0;
    end else begin
      st      <= nxt;
      ds_prev <= ds_s;
      if (st == ST_IDLE && nxt != ST_IDLE) cyc_rd <= rw_s;
      if (st == ST_RLOAD) rd_data <= mem_q;
      dtack_n  <= (nxt != ST_ACK);
      drive_en <= (nxt == ST_RDRIVE) ||
                  (nxt == ST_ACK && st != ST_IDLE && cyc_rd);
    end
  end

  assign bus_data = drive_en ? rd_data : 'z;

  // R5: drive only follows a cycle with strobe and select both active
  assert_drive_window_R5: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> $past(!ds_s && !cs_s));

  // R6: a read acknowledge is preceded by the data drive
  assert_data_before_ack_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(dtack_n) && cyc_rd) |-> $past(drive_en));

  // R7: an inactive strobe leaves the acknowledge released
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ds_s) |-> dtack_n);

  // R8: a deselected slave never acknowledges
  assert_no_ack_deselect_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> dtack_n);

  // R9: no transfer starts without a latched address
  assert_need_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> addr_vld);

endmodule

// File: tb/tb_mbus_slave.sv
module tb_mbus_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] bus_addr = '0;
  logic        cs_n = 1'b1, as_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic        dtack_n;
  logic        tb_oe = 1'b0;
  logic [7:0]  tb_val = '0;
  wire  [7:0]  bus_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] model [64];

  assign bus_data = tb_oe ? tb_val : 8'bz;

  always #5 clk = ~clk;

  mbus_slave dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .cs_n(cs_n), .as_n(as_n), .rw(rw), .ds_n(ds_n), .dtack_n(dtack_n)
  );

  function automatic int loc(input logic [14:0] a);
    return int'(a) % 64;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle. cs_low selects the chip, do_as latches 'a',
  // a_late is placed on the address bus before the data strobe.
  task automatic cycle(input logic cs_low, input logic do_as,
                       input logic [14:0] a, input logic [14:0] a_late,
                       input logic is_rd, input logic [7:0] wd,
                       output logic acked, output logic [7:0] rd,
                       output int rel);
    @(negedge clk);
    bus_addr = a;
    cs_n = !cs_low;
    if (do_as) begin
      as_n = 1'b0;
      repeat (3) @(negedge clk);
      as_n = 1'b1;
    end
    repeat (4) @(negedge clk);
    bus_addr = a_late;
    rw = is_rd;
    if (!is_rd) begin
      tb_oe  = 1'b1;
      tb_val = wd;
    end
    @(negedge clk);
    ds_n  = 1'b0;
    acked = 1'b0;
    rd    = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!dtack_n) begin
        acked = 1'b1;
        rd    = bus_data;
        break;
      end
    end
    ds_n = 1'b1;
    rel  = 0;
    for (int i = 0; i < 10; i++) begin
      if (dtack_n) break;
      @(negedge clk);
      rel++;
    end
    tb_oe = 1'b0;
    rw    = 1'b1;
    cs_n  = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input string req);
    logic ack; logic [7:0] r; int rel;
    cycle(1'b1, 1'b1, a, a, 1'b0, d, ack, r, rel);
    check(req, ack, 1'b1);
    check("R7", rel <= 4, 1'b1);
    model[loc(a)] = d;
  endtask

  task automatic rd_chk(input logic [14:0] a, input string req);
    logic ack; logic [7:0] r; int rel;
    cycle(1'b1, 1'b1, a, a, 1'b1, 8'h00, ack, r, rel);
    check(req, ack, 1'b1);
    check(req, r, model[loc(a)]);
    check("R7", rel <= 4, 1'b1);
  endtask

  initial begin
    logic ack; logic [7:0] r; int rel;
    logic [14:0] a;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 dtack", dtack_n, 1'b1);
    tb_oe = 1'b1; tb_val = 8'hA5;
    @(negedge clk);
    check("R1 bus free", bus_data, 8'hA5);
    tb_oe = 1'b0;

    // R9: data strobe without any latched address
    cycle(1'b1, 1'b0, 15'h0003, 15'h0003, 1'b0, 8'h77, ack, r, rel);
    check("R9 no ack", ack, 1'b0);

    // R3 R4: directed write then read
    wr(15'h0003, 8'h3C, "R3");
    rd_chk(15'h0003, "R4");
    wr(15'h7FFF, 8'hE1, "R3");
    rd_chk(15'h7FFF, "R4");

    // R3: aliasing above bit 5
    wr(15'h0045, 8'h9A, "R3");
    model[5] = 8'h9A;
    rd_chk(15'h0005, "R3 alias");

    // R2: a late address change is ignored
    cycle(1'b1, 1'b1, 15'h0010, 15'h0020, 1'b0, 8'h5D, ack, r, rel);
    check("R2 ack", ack, 1'b1);
    model[16] = 8'h5D;
    wr(15'h0020, 8'h11, "R2");
    rd_chk(15'h0010, "R2");

    // R8: deselected write has no effect
    cycle(1'b0, 1'b1, 15'h0010, 15'h0010, 1'b0, 8'hFF, ack, r, rel);
    check("R8 no ack", ack, 1'b0);
    rd_chk(15'h0010, "R8");

    // R5 R6: after a read the bus is released
    rd_chk(15'h0020, "R6");
    tb_oe = 1'b1; tb_val = 8'h3E;
    @(negedge clk);
    check("R5 released", bus_data, 8'h3E);
    tb_oe = 1'b0;

    // Random writes followed by reads of the same locations
    for (int k = 0; k < 30; k++) begin
      a = 15'($urandom);
      wr(a, 8'($urandom), "R3");
      rd_chk(a, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule